// File: doc/BRIEF.md
# Strided-Tap Four-Coefficient Wavelet Line Filter

This block filters one video line at a time for an undecimated wavelet transform. It accepts one signed 16-bit sample per clock into a shift chain of thirteen registers. Four taps are taken from that chain, and the distance between them is 1, 2 or 4 registers, chosen by the decomposition level. Each coarser scale therefore behaves like the base four-tap filter with zeros inserted between its coefficients, although no zeros are ever stored. The taps are weighted by a low-pass or a high-pass set of Q1.14 coefficients. The multiply-add is pipelined, and the result is rounded and clipped to 16 bits.

The same instance serves analysis and synthesis. A mirror control reverses the coefficient order for the inverse transform. Level, band and mirror settings are captured only with the first sample of a line, so the taps never change partway through a line. The first sample of a line also empties the older part of the chain, which means samples near the left edge are filtered against zeros. The caller feeds 8-bit pixels zero-extended to 16 bits, or 16-bit coefficients from an earlier scale.

Top module: `atrous_fir`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `out_data` is 0. All thirteen chain registers are zero.
- R2: With level code 0, output n is the sum over k=0..3 of c[k]·x[n−k], where k=0 is the newest sample.
- R3: With level code 1, the tap spacing is 2 (x[n], x[n−2], x[n−4], x[n−6]). With level codes 2 and 3, the spacing is 4 (x[n] … x[n−12]).
- R4: With `band_sel`=0, c = (7913, 13705, 3672, −2120). With `band_sel`=1, c = (−2120, −3672, 13705, −7913). Both sets are listed for k=0..3 and are Q1.14.
- R5: With `mirror_sel`=1, the order is reversed: tap k is weighted by c[3−k].
- R6: The full-precision sum S gives the output (S + 8192) >>> 14, clipped to the range −32768..32767.
- R7: `out_valid` equals `in_valid` delayed by exactly 3 clock edges. The output that appears with it belongs to the sample accepted at that earlier edge.
- R8: An accepted sample with `line_start`=1 loads the newest register and clears the other twelve, so no sample of an earlier line reaches any output of the new line.
- R9: Level, band and mirror are captured only when `line_start` and `in_valid` are both 1. Changes at any other time have no effect on the outputs.
- R10: While `in_valid` is 0 the chain holds its contents and no output is produced. Gaps inside a line do not change the results, and `out_data` holds its value while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present on `in_sample` |
| line_start | input | 1 | Marks the first sample of a line |
| in_sample | input | 16 | Signed input sample |
| level_sel | input | 2 | Scale code: 0 spacing 1, 1 spacing 2, 2 or 3 spacing 4 |
| band_sel | input | 1 | 0 low-pass, 1 high-pass coefficients |
| mirror_sel | input | 1 | 1 reverses the coefficient order |
| out_valid | output | 1 | Filtered sample present |
| out_data | output | 16 | Signed rounded and clipped result |

## Verification
On every cycle, the checker confirms four things. The valid signal trails the input valid by three edges. The output word stays put between results. The captured settings change only on an accepted line start. A line start leaves twelve zeroed registers behind the new sample. The arithmetic itself can only be shown by the bench's lines: tap spacing at each scale, coefficient choice and reversal, rounding and clipping, and the absence of carry-over between lines. The bench compares these against a filter model written from the coefficient and spacing rules. It also covers mid-line setting changes and gapped input.

// File: rtl/atrous_pkg.sv
// Shared types for the strided-tap wavelet line filter.
// Assumes nothing beyond the parameter defaults of the modules that import it.
package atrous_pkg;

    // Per-line settings captured with the first sample of a line.
    typedef struct packed {
        logic [1:0] level;   // 0: spacing 1, 1: spacing 2, 2/3: spacing 4
        logic       band;    // 0 low-pass, 1 high-pass
        logic       mirror;  // 1 reverses the coefficient order
    } atrous_cfg_t;

endpackage

// File: rtl/atrous_delay_line.sv
// Sample shift chain. On each accepted sample the newest register loads the
// input. When the sample starts a line, every older register is cleared;
// otherwise each older register takes its neighbour's value.
// Assumes in_valid qualifies in_sample and line_start.
module atrous_delay_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     line_start,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic signed [DATA_W-1:0] chain [DEPTH]
);

    // Shift, clear or hold the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
        end else if (in_valid) begin
            chain[0] <= in_sample;
            for (int i = 1; i < DEPTH; i++)
                chain[i] <= line_start ? '0 : chain[i-1];
        end
    end

endmodule

// File: rtl/atrous_tap_select.sv
// Picks four taps from the chain at a spacing of 2**level and supplies the
// matching coefficient set, reversed when mirror is set. Level codes at or
// above NLEVELS-1 use the widest spacing. The high-pass set is derived from
// the low-pass set by quadrature mirroring.
module atrous_tap_select
    import atrous_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int NTAPS   = 4,
    parameter int NLEVELS = 3,
    parameter int DEPTH   = (NTAPS - 1) * (1 << (NLEVELS - 1)) + 1,
    parameter logic signed [COEF_W-1:0] LP_COEF [NTAPS] = '{16'sd7913, 16'sd13705, 16'sd3672, -16'sd2120}
) (
    input  logic signed [DATA_W-1:0] chain [DEPTH],
    input  atrous_cfg_t              cfg,
    output logic signed [DATA_W-1:0] taps  [NTAPS],
    output logic signed [COEF_W-1:0] coefs [NTAPS]
);

    logic signed [COEF_W-1:0] hp_coef [NTAPS];

    genvar k;
    generate
        for (k = 0; k < NTAPS; k++) begin : g_tap
            // High-pass coefficient k: alternate sign of reversed low-pass.
            if (k % 2 == 0) begin : g_even
                assign hp_coef[k] = LP_COEF[NTAPS-1-k];
            end else begin : g_odd
                assign hp_coef[k] = -LP_COEF[NTAPS-1-k];
            end

            // Tap k sits k*2**level registers behind the newest sample.
            always_comb begin
                taps[k] = chain[k << (NLEVELS - 1)];
                for (int l = 0; l < NLEVELS - 1; l++)
                    if (int'(cfg.level) == l) taps[k] = chain[k << l];
            end

            // Coefficient for tap k: band choice, then optional reversal.
            always_comb begin
                if (cfg.mirror)
                    coefs[k] = cfg.band ? hp_coef[NTAPS-1-k] : LP_COEF[NTAPS-1-k];
                else
                    coefs[k] = cfg.band ? hp_coef[k] : LP_COEF[k];
            end
        end
    endgenerate

endmodule

// File: rtl/atrous_mac.sv
// Two-stage multiply-add. Stage one registers the four products. Stage two
// sums them at full width, rounds half up at bit FRAC-1, clips to DATA_W and
// registers the result, which is held while no valid result arrives.
module atrous_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 4,
    parameter int FRAC   = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_v,
    input  logic signed [DATA_W-1:0] taps  [NTAPS],
    input  logic signed [COEF_W-1:0] coefs [NTAPS],
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NTAPS);
    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV  = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV  = -(ACC_W'(1) <<< (DATA_W - 1));

    logic signed [PROD_W-1:0] prod_q [NTAPS];
    logic                     prod_v;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  rnd;
    logic signed [DATA_W-1:0] clip;

    // Register the products and their valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_v <= 1'b0;
            for (int k = 0; k < NTAPS; k++) prod_q[k] <= '0;
        end else begin
            prod_v <= in_v;
            for (int k = 0; k < NTAPS; k++) prod_q[k] <= taps[k] * coefs[k];
        end
    end

    // Sum at full width, round, and clip.
    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++) acc = acc + ACC_W'(prod_q[k]);
        rnd = (acc + HALF) >>> FRAC;
        if (rnd > MAXV)      clip = MAXV[DATA_W-1:0];
        else if (rnd < MINV) clip = MINV[DATA_W-1:0];
        else                 clip = rnd[DATA_W-1:0];
    end

    // Register the result; hold the data word between results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= prod_v;
            if (prod_v) out_data <= clip;
        end
    end

endmodule

// File: rtl/atrous_fir.sv
// Top of the strided-tap wavelet line filter. It captures the per-line
// settings with the first sample, feeds the shift chain, selects taps and
// coefficients, and runs the two-stage multiply-add. Latency is three edges.
// Assumes line_start is only meaningful together with in_valid.
module atrous_fir
    import atrous_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int NTAPS   = 4,
    parameter int NLEVELS = 3,
    parameter int FRAC    = 14,
    parameter logic signed [COEF_W-1:0] LP_COEF [NTAPS] = '{16'sd7913, 16'sd13705, 16'sd3672, -16'sd2120}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     line_start,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic [1:0]               level_sel,
    input  logic                     band_sel,
    input  logic                     mirror_sel,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int DEPTH = (NTAPS - 1) * (1 << (NLEVELS - 1)) + 1;

    atrous_cfg_t              cfg_q;
    logic                     chain_v;
    logic signed [DATA_W-1:0] chain [DEPTH];
    logic signed [DATA_W-1:0] taps  [NTAPS];
    logic signed [COEF_W-1:0] coefs [NTAPS];

    // Capture the settings with the first sample of a line; track valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            chain_v <= 1'b0;
        end else begin
            chain_v <= in_valid;
            if (in_valid && line_start)
                cfg_q <= '{level: level_sel, band: band_sel, mirror: mirror_sel};
        end
    end

    atrous_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .line_start (line_start),
        .in_sample  (in_sample),
        .chain      (chain)
    );

    atrous_tap_select #(
        .DATA_W (DATA_W), .COEF_W (COEF_W), .NTAPS (NTAPS),
        .NLEVELS(NLEVELS), .DEPTH (DEPTH), .LP_COEF(LP_COEF)
    ) u_sel (
        .chain (chain),
        .cfg   (cfg_q),
        .taps  (taps),
        .coefs (coefs)
    );

    atrous_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .FRAC(FRAC)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (chain_v),
        .taps      (taps),
        .coefs     (coefs),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/atrous_fir_chk.sv
// Checker for atrous_fir, attached with bind. It tracks the edges since
// reset so that no property looks back before reset was released.
module atrous_fir_chk
    import atrous_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     line_start,
    input logic signed [DATA_W-1:0] in_sample,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_data,
    input atrous_cfg_t              cfg_q,
    input logic signed [DATA_W-1:0] chain [DEPTH]
);

    logic [1:0] since_rst = 2'd0;
    logic       started   = 1'b0;
    logic       tail_zero;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // All registers behind the newest one are zero.
    always_comb begin
        tail_zero = 1'b1;
        for (int i = 1; i < DEPTH; i++)
            if (chain[i] != '0) tail_zero = 1'b0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        (started && $past(!rst_n)) |-> (!out_valid && out_data == '0 && tail_zero && chain[0] == '0));

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_line_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(in_valid && line_start)) |-> (tail_zero && chain[0] == $past(in_sample)));

    assert_cfg_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && cfg_q != $past(cfg_q)) |-> $past(in_valid && line_start));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |-> $stable(out_data));

endmodule

bind atrous_fir atrous_fir_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .line_start (line_start),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .cfg_q      (cfg_q),
    .chain      (chain)
);

// File: tb/tb_atrous_fir.sv
// Bench for atrous_fir: a table of line scenarios walked by one loop, then
// directed checks for reset, latency, line clearing and rounding.
module tb_atrous_fir;

    localparam int LEN  = 16;
    localparam int NROW = 12;

    // Row: {level[8:7], band[6], mirror[5], pattern[4:2], gap[1], change[0]}
    localparam logic [8:0] ROWS [NROW] = '{
        {2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0},
        {2'd0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1},
        {2'd0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1},
        {2'd1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               line_start = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic [1:0]         level_sel = '0;
    logic               band_sel = 1'b0;
    logic               mirror_sel = 1'b0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int errors = 0;
    int checks = 0;
    int ncap = 0;
    logic signed [15:0] cap [64];
    int xs [LEN];
    bit done = 1'b0;

    always #5 clk = ~clk;

    atrous_fir dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_start(line_start),
        .in_sample(in_sample), .level_sel(level_sel), .band_sel(band_sel),
        .mirror_sel(mirror_sel), .out_valid(out_valid), .out_data(out_data)
    );

    // Collect every result away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && ncap < 64) begin
            cap[ncap] = out_data;
            ncap++;
        end
    end

    task automatic check(input string tag, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int pat_val(input int p, input int i);
        case (p)
            0:       return (i == 0) ? 16384 : 0;
            1:       return i * 1000 - 9000;
            2:       return (i % 2 == 1) ? -32768 : 32767;
            3:       return 200;
            default: return ((i * 7919) % 4001) - 2000;
        endcase
    endfunction

    // Expected output from the requirement formulas (R2 to R6).
    function automatic int model(input int n, input int lvl, input bit band, input bit mir);
        int lp [4] = '{7913, 13705, 3672, -2120};
        int hp [4] = '{-2120, -3672, 13705, -7913};
        int s;
        longint acc;
        longint r;
        s = (lvl == 0) ? 1 : (lvl == 1) ? 2 : 4;
        acc = 0;
        for (int k = 0; k < 4; k++) begin
            int c;
            int idx;
            c = band ? (mir ? hp[3-k] : hp[k]) : (mir ? lp[3-k] : lp[k]);
            idx = n - k * s;
            if (idx >= 0) acc += longint'(c) * longint'(xs[idx]);
        end
        r = (acc + 8192) >>> 14;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // Drive one line; optionally insert gaps and change settings mid-line.
    task automatic send_line(input int lvl, input bit band, input bit mir, input int len,
                             input bit gap, input bit chg);
        ncap = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            line_start = (i == 0);
            in_sample  = 16'(xs[i]);
            if (chg && i >= len / 2) begin
                level_sel = 2'(lvl + 1); band_sel = ~band; mirror_sel = ~mir;
            end else begin
                level_sel = 2'(lvl); band_sel = band; mirror_sel = mir;
            end
            if (gap && i % 2 == 1) begin
                @(negedge clk);
                in_valid = 1'b0; line_start = 1'b0; in_sample = 16'sd999;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; line_start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs.
        check("R1", int'(out_valid), 0, "out_valid in reset");
        check("R1", int'(out_data), 0, "out_data in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0, "out_valid after reset");

        // R7: a single sample appears exactly three edges later.
        xs[0] = 16384;
        @(negedge clk);
        in_valid = 1'b1; line_start = 1'b1; in_sample = 16'sd16384;
        level_sel = 2'd0; band_sel = 1'b0; mirror_sel = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; line_start = 1'b0;
        check("R7", int'(out_valid), 0, "valid after one edge");
        @(negedge clk);
        check("R7", int'(out_valid), 0, "valid after two edges");
        @(negedge clk);
        check("R7", int'(out_valid), 1, "valid after three edges");
        check("R7", int'(out_data), 7913, "data with valid");
        @(negedge clk);
        check("R7", int'(out_valid), 0, "valid drops after one result");
        check("R10", int'(out_data), 7913, "data held while idle");
        repeat (2) @(negedge clk);

        // Table of line scenarios (R2 to R6, R9, R10).
        for (int r = 0; r < NROW; r++) begin
            int lvl;
            bit band;
            bit mir;
            int p;
            bit gap;
            bit chg;
            string tag;
            lvl  = int'(ROWS[r][8:7]);
            band = ROWS[r][6];
            mir  = ROWS[r][5];
            p    = int'(ROWS[r][4:2]);
            gap  = ROWS[r][1];
            chg  = ROWS[r][0];
            if (chg)            tag = "R9";
            else if (gap)       tag = "R10";
            else if (p == 2)    tag = "R6";
            else if (mir)       tag = "R5";
            else if (band)      tag = "R4";
            else if (lvl == 0)  tag = "R2";
            else                tag = "R3";
            for (int i = 0; i < LEN; i++) xs[i] = pat_val(p, i);
            send_line(lvl, band, mir, LEN, gap, chg);
            check(tag, ncap, LEN, $sformatf("row %0d result count", r));
            for (int i = 0; i < LEN && i < ncap; i++)
                check(tag, int'(cap[i]), model(i, lvl, band, mir),
                      $sformatf("row %0d sample %0d", r, i));
        end

        // R8: a new line must not see the previous line's samples.
        for (int i = 0; i < LEN; i++) xs[i] = 16384;
        send_line(0, 1'b0, 1'b0, LEN, 1'b0, 1'b0);
        xs[0] = 0; xs[1] = 0; xs[2] = 0;
        send_line(0, 1'b0, 1'b0, 3, 1'b0, 1'b0);
        check("R8", ncap, 3, "result count after clear");
        check("R8", int'(cap[0]), 0, "first output of new line");
        check("R8", int'(cap[2]), 0, "third output of new line");

        // R6: rounding of small sums, half-up at bit 13.
        xs[0] = 2; xs[1] = -2;
        send_line(0, 1'b0, 1'b0, 2, 1'b0, 1'b0);
        check("R6", int'(cap[0]), 1, "2*7913 rounded");
        check("R6", int'(cap[1]), 1, "2*13705-2*7913 rounded");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule